// File: doc/BRIEF.md
# Monitor ADC Register Bank and Acquisition Sequencer

This block is the digital core that sits behind a serial-bus slave in an environmental monitoring converter. The serial-bus engine turns bus transfers into simple register reads and writes on a 3-bit address. The block decodes them into a control register, a status register that also carries the upper result bits, a register for the lower result bits, and three read-only bytes of a fixed 24-bit serial number. Writing the start bit of the control register launches one conversion on the chosen input channel and mode. The block then shows itself busy until the converter reports completion, and it captures the 12-bit result.

The control state is the channel, the mode and the busy flag. It is kept in three copies, and a bitwise majority vote gives the value in use. Every clock writes the voted value back into all three copies, so a single upset copy is repaired on the next edge. Any disagreement between the copies raises a sticky error flag in the status register. The synchronous external reset returns the block to its reset state, and so does a write of the soft-reset bit.

Top module: `mon_adc_regs`

## Requirements
- R1: While and after `rst`, `adc_start` is 0 and reads return: control (address 000) 0x00, status (address 001) 0x80, low result (address 011) 0x00.
- R2: A write to address 000 without bit 6 stores bits [2:0] as the channel and bit 3 as the mode. These appear on `adc_chan`/`adc_mode` and read back at the same positions; bits 7:4 read 0, so the start bit always reads 0.
- R3: A write to address 000 with bit 7 = 1 and bit 6 = 0 while idle drives `adc_start` high for exactly the one cycle after the write edge and clears status bit 7 (idle). The same write while busy gives no start pulse.
- R4: `adc_done` high at an edge while busy sets status bit 7 again. `adc_done` while idle has no effect.
- R5: On the edge that ends a conversion, `adc_result[11:8]` is loaded into status bits [3:0] and `adc_result[7:0]` into address 011, both together. At all other times both hold.
- R6: Address 101 reads serial bits [7:0], address 110 reads bits [15:8], and address 111 reads bits [23:16] of parameter `SERIAL_ID`.
- R7: Addresses 010 and 100 read 0x00. A write to any address other than 000 changes no register.
- R8: A write to address 000 with bit 6 = 1 resets channel, mode, busy, result and error flag at that edge, whatever the other bits are.
- R9: If one copy of the triplicated control state differs from the others, the voted channel, mode and busy are unchanged. Status bit 6 becomes 1 and stays 1 until a reset, and the faulty copy is rewritten on the next edge.
- R10: `rd_data` takes the addressed value on the edge where `reg_rd` is high and holds it while `reg_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | External synchronous reset, active high |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| adc_start | output | 1 | One-cycle conversion start pulse |
| adc_chan | output | 3 | Selected input channel |
| adc_mode | output | 1 | Selected conversion mode |
| adc_done | input | 1 | Converter completion indication |
| adc_result | input | 12 | Converter result, valid with `adc_done` |

## Verification
If the busy flag is wrong, a start pulse goes missing or comes twice, or the status idle bit is stuck. Either shows on `adc_start` one cycle after the write, or on the next status read. A corrupted result register shows in the status and low reads of that same conversion. Upset handling is exercised by forcing one control copy: the voted channel must still read back right, and the error bit must be set on the next status read and stay set until reset. The assertions catch a missed capture, a start pulse while busy, or a lost sticky flag within one cycle.

// File: rtl/mon_adc_pkg.sv
package mon_adc_pkg;
  parameter int DATA_W = 8;
  parameter int ADDR_W = 3;
  parameter int CHAN_W = 3;
  parameter int RES_W  = 12;
  parameter int ID_W   = 24;
  localparam int HI_W  = RES_W - DATA_W;
  localparam int WORD_W = CHAN_W + 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'b000;
  localparam logic [ADDR_W-1:0] A_STAT = 3'b001;
  localparam logic [ADDR_W-1:0] A_LOW  = 3'b011;
  localparam logic [ADDR_W-1:0] A_ID0  = 3'b101;
  localparam logic [ADDR_W-1:0] A_ID1  = 3'b110;
  localparam logic [ADDR_W-1:0] A_ID2  = 3'b111;

  localparam int B_MODE  = 3;
  localparam int B_SRST  = 6;
  localparam int B_START = 7;
  localparam int B_ERR   = 6;
  localparam int B_IDLE  = 7;

  typedef struct packed {
    logic              busy;
    logic              mode;
    logic [CHAN_W-1:0] chan;
  } ctrl_word_t;
endpackage

// File: rtl/tmr_reg.sv
module tmr_reg #(
  parameter int W = 5,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         mismatch
);
  logic [W-1:0] q0, q1, q2;
  logic [W-1:0] nxt;

  assign q        = (q0 & q1) | (q1 & q2) | (q0 & q2);
  assign mismatch = (q0 != q1) || (q1 != q2);
  assign nxt      = we ? d : q;

  // every copy is rewritten each cycle, so one flipped copy is scrubbed
  always_ff @(posedge clk) begin
    if (rst) begin
      q0 <= RST_VAL;
      q1 <= RST_VAL;
      q2 <= RST_VAL;
    end else begin
      q0 <= nxt;
      q1 <= nxt;
      q2 <= nxt;
    end
  end
endmodule

// File: rtl/mon_adc_seq.sv
module mon_adc_seq
  import mon_adc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CHAN_W-1:0] cfg_chan,
  input  logic              cfg_mode,
  input  logic              start_req,
  input  logic              adc_done,
  output logic [CHAN_W-1:0] chan,
  output logic              mode,
  output logic              busy,
  output logic              mismatch,
  output logic              adc_start,
  output logic              capture
);
  ctrl_word_t cur, nxt;
  logic launch;
  logic [WORD_W-1:0] cur_bits;

  assign cur    = ctrl_word_t'(cur_bits);
  assign launch = start_req && !cur.busy;
  assign capture = adc_done && cur.busy;

  always_comb begin
    nxt = cur;
    if (cfg_we) begin
      nxt.chan = cfg_chan;
      nxt.mode = cfg_mode;
    end
    if (launch)       nxt.busy = 1'b1;
    else if (capture) nxt.busy = 1'b0;
  end

  tmr_reg #(.W(WORD_W), .RST_VAL('0)) u_word (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we || launch || capture),
    .d        (nxt),
    .q        (cur_bits),
    .mismatch (mismatch)
  );

  always_ff @(posedge clk) begin
    if (rst) adc_start <= 1'b0;
    else     adc_start <= launch;
  end

  assign chan = cur.chan;
  assign mode = cur.mode;
  assign busy = cur.busy;
endmodule

// File: rtl/mon_adc_result.sv
module mon_adc_result
  import mon_adc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic [RES_W-1:0] adc_result,
  output logic [RES_W-1:0] res_q
);
  always_ff @(posedge clk) begin
    if (rst)          res_q <= '0;
    else if (capture) res_q <= adc_result;
  end
endmodule

// File: rtl/mon_adc_regs.sv
module mon_adc_regs
  import mon_adc_pkg::*;
#(
  parameter logic [ID_W-1:0] SERIAL_ID = 24'hA5C31E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] rd_data,
  output logic              adc_start,
  output logic [CHAN_W-1:0] adc_chan,
  output logic              adc_mode,
  input  logic              adc_done,
  input  logic [RES_W-1:0]  adc_result
);
  logic ctrl_sel, soft_rst, int_rst, cfg_we, start_req;
  logic busy, stat_idle, tmr_mismatch, capture, err_q;
  logic [RES_W-1:0]  res_q;
  logic [DATA_W-1:0] rd_mux;
  logic [1:0]        wdata_unused;

  assign wdata_unused = reg_wdata[5:4];
  assign ctrl_sel  = reg_wr && (reg_addr == A_CTRL);
  assign soft_rst  = ctrl_sel && reg_wdata[B_SRST];
  assign int_rst   = rst || soft_rst;
  assign cfg_we    = ctrl_sel && !reg_wdata[B_SRST];
  assign start_req = cfg_we && reg_wdata[B_START];
  assign stat_idle = !busy;

  mon_adc_seq u_seq (
    .clk       (clk),
    .rst       (int_rst),
    .cfg_we    (cfg_we),
    .cfg_chan  (reg_wdata[CHAN_W-1:0]),
    .cfg_mode  (reg_wdata[B_MODE]),
    .start_req (start_req),
    .adc_done  (adc_done),
    .chan      (adc_chan),
    .mode      (adc_mode),
    .busy      (busy),
    .mismatch  (tmr_mismatch),
    .adc_start (adc_start),
    .capture   (capture)
  );

  mon_adc_result u_res (
    .clk        (clk),
    .rst        (int_rst),
    .capture    (capture),
    .adc_result (adc_result),
    .res_q      (res_q)
  );

  always_ff @(posedge clk) begin
    if (int_rst)           err_q <= 1'b0;
    else if (tmr_mismatch) err_q <= 1'b1;
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_CTRL: begin
        rd_mux[CHAN_W-1:0] = adc_chan;
        rd_mux[B_MODE]     = adc_mode;
      end
      A_STAT: begin
        rd_mux[HI_W-1:0] = res_q[RES_W-1:DATA_W];
        rd_mux[B_ERR]    = err_q;
        rd_mux[B_IDLE]   = stat_idle;
      end
      A_LOW: rd_mux = res_q[DATA_W-1:0];
      A_ID0: rd_mux = SERIAL_ID[0*DATA_W +: DATA_W];
      A_ID1: rd_mux = SERIAL_ID[1*DATA_W +: DATA_W];
      A_ID2: rd_mux = SERIAL_ID[2*DATA_W +: DATA_W];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (reg_rd) rd_data <= rd_mux;
  end
endmodule

// File: rtl/mon_adc_chk.sv
module mon_adc_chk
  import mon_adc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              reg_wr,
  input logic              adc_start,
  input logic [CHAN_W-1:0] adc_chan,
  input logic              adc_mode,
  input logic              adc_done,
  input logic [RES_W-1:0]  adc_result,
  input logic              idle,
  input logic              err,
  input logic              mismatch,
  input logic [RES_W-1:0]  res
);
  logic ctrl_wr, srst;
  assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
  assign srst    = ctrl_wr && reg_wdata[B_SRST];

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    adc_start |=> !adc_start); // R3
  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && reg_wdata[B_START] && !reg_wdata[B_SRST] && idle) |=> (adc_start && !idle)); // R3
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !idle) |=> !adc_start); // R3
  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (adc_done && !idle) |=> idle); // R4
  AST_RESULT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (adc_done && !idle && !srst) |=> (res == $past(adc_result))); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!(adc_done && !idle) && !srst) |=> $stable(res)); // R5
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctrl_wr |=> $stable({adc_chan, adc_mode})); // R7
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (rst)
    srst |=> (idle && !err && res == '0 && adc_chan == '0 && !adc_mode)); // R8
  AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
    (mismatch && !srst) |=> err); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err && !srst) |=> err); // R9
endmodule

bind mon_adc_regs mon_adc_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_wr     (reg_wr),
  .adc_start  (adc_start),
  .adc_chan   (adc_chan),
  .adc_mode   (adc_mode),
  .adc_done   (adc_done),
  .adc_result (adc_result),
  .idle       (stat_idle),
  .err        (err_q),
  .mismatch   (tmr_mismatch),
  .res        (res_q)
);

// File: tb/tb_mon_adc_regs.sv
module tb_mon_adc_regs;
  localparam logic [23:0] SID = 24'h5E9D27;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  rd_data;
  logic        adc_start;
  logic [2:0]  adc_chan;
  logic        adc_mode;
  logic        adc_done = 1'b0;
  logic [11:0] adc_result = '0;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mon_adc_regs #(.SERIAL_ID(SID)) dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .rd_data(rd_data),
    .adc_start(adc_start), .adc_chan(adc_chan), .adc_mode(adc_mode),
    .adc_done(adc_done), .adc_result(adc_result)
  );

  typedef struct packed {
    logic       rd;
    logic [2:0] addr;
    logic [7:0] data;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'b000, 8'h0D, 8'h00, 4'd2},   // R2 chan 5 mode 1
    '{1'b1, 3'b000, 8'h00, 8'h0D, 4'd2},   // R2 readback
    '{1'b0, 3'b000, 8'h3A, 8'h00, 4'd2},   // R2 bits 5:4 dropped
    '{1'b1, 3'b000, 8'h00, 8'h0A, 4'd2},   // R2
    '{1'b0, 3'b010, 8'hFF, 8'h00, 4'd7},   // R7 write unused
    '{1'b0, 3'b001, 8'hFF, 8'h00, 4'd7},   // R7 write status
    '{1'b1, 3'b000, 8'h00, 8'h0A, 4'd7},   // R7 control untouched
    '{1'b1, 3'b010, 8'h00, 8'h00, 4'd7},   // R7
    '{1'b1, 3'b100, 8'h00, 8'h00, 4'd7},   // R7
    '{1'b1, 3'b101, 8'h00, 8'h27, 4'd6},   // R6
    '{1'b1, 3'b110, 8'h00, 8'h9D, 4'd6},   // R6
    '{1'b1, 3'b111, 8'h00, 8'h5E, 4'd6},   // R6
    '{1'b1, 3'b001, 8'h00, 8'h80, 4'd3},   // R3 idle, no result yet
    '{1'b1, 3'b011, 8'h00, 8'h00, 4'd5}    // R5
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    v = rd_data;
  endtask

  task automatic finish_conv(input logic [11:0] r);
    @(negedge clk);
    adc_result = r; adc_done = 1'b1;
    @(negedge clk);
    adc_done = 1'b0;
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      report();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 start", {15'd0, adc_start}, 16'd0);
    rst = 1'b0;
    do_read(3'b000, v); chk("R1 ctrl", v, 8'h00);
    do_read(3'b001, v); chk("R1 status", v, 8'h80);
    do_read(3'b011, v); chk("R1 low", v, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].rd) begin
        do_read(VECS[i].addr, v);
        chk($sformatf("R%0d vec %0d", VECS[i].req, i), v, VECS[i].exp);
      end else begin
        do_write(VECS[i].addr, VECS[i].data);
      end
    end
    chk("R2 pins", {12'd0, adc_mode, adc_chan}, 16'h000A);

    // R10 hold while reg_rd low
    do_read(3'b101, v);
    @(negedge clk); reg_addr = 3'b111;
    repeat (3) @(negedge clk);
    chk("R10 hold", rd_data, 8'h27);

    // R3 start from idle: chan 5, mode 0
    do_write(3'b000, 8'h85);
    chk("R3 pulse", {15'd0, adc_start}, 16'd1);
    chk("R2 chan at start", {13'd0, adc_chan}, 16'd5);
    @(negedge clk);
    chk("R3 pulse width", {15'd0, adc_start}, 16'd0);
    do_read(3'b001, v); chk("R3 busy status", v, 8'h00);
    do_read(3'b000, v); chk("R2 start reads 0", v, 8'h05);
    // R3 start while busy ignored
    do_write(3'b000, 8'h83);
    chk("R3 no start busy", {15'd0, adc_start}, 16'd0);
    // R4/R5 completion
    finish_conv(12'hABC);
    do_read(3'b001, v); chk("R4 R5 status", v, 8'h8A);
    do_read(3'b011, v); chk("R5 low", v, 8'hBC);
    // R4 done while idle ignored
    finish_conv(12'h123);
    do_read(3'b001, v); chk("R4 idle done status", v, 8'h8A);
    do_read(3'b011, v); chk("R4 idle done low", v, 8'hBC);

    // R9 single-copy upset: word {busy,mode,chan} = 0_1_011
    do_write(3'b000, 8'h0B);
    @(negedge clk);
    force dut.u_seq.u_word.q1 = 5'b01010;
    @(negedge clk);
    release dut.u_seq.u_word.q1;
    chk("R9 voted chan", {12'd0, adc_mode, adc_chan}, 16'h000B);
    do_read(3'b000, v); chk("R9 ctrl readback", v, 8'h0B);
    do_read(3'b001, v); chk("R9 err set", v, 8'hCA);
    repeat (4) @(negedge clk);
    do_read(3'b001, v); chk("R9 err sticky", v, 8'hCA);
    do_write(3'b000, 8'h88);
    chk("R9 start after scrub", {15'd0, adc_start}, 16'd1);
    finish_conv(12'h5F0);
    do_read(3'b011, v); chk("R5 second low", v, 8'hF0);

    // R8 soft reset with start bit also set
    do_write(3'b000, 8'hCF);
    chk("R8 no start", {15'd0, adc_start}, 16'd0);
    do_read(3'b000, v); chk("R8 ctrl", v, 8'h00);
    do_read(3'b001, v); chk("R8 status", v, 8'h80);
    do_read(3'b011, v); chk("R8 low", v, 8'h00);

    // R1 external reset
    do_write(3'b000, 8'h0F);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    do_read(3'b000, v); chk("R1 ext ctrl", v, 8'h00);
    chk("R1 ext pins", {12'd0, adc_mode, adc_chan}, 16'h0000);

    finished = 1'b1;
    report();
    $finish;
  end
endmodule